// File: doc/BRIEF.md
# Shared Timer Unit with Watchdog Channel

This block holds one 16-bit up-counter that six capture/compare channels share. The counter advances on pulses from one of seven timebases. Three of them come from the system clock: undivided, divided by 4, or divided by 12. Two are free-running slow clocks, each divided by 8. The last two are event inputs: a timer-0 overflow pulse and a general count input. Every source other than the system clock and its dividers is brought into the system clock domain through a synchroniser and counted on its rising edge. A byte-wide register port configures the block and reads its state. Each channel drives one output line that shows its event flag.

Each channel can capture the counter on a rising edge of its own input. It can also raise a flag when the counter steps onto the value held in the channel. The last channel is a watchdog at reset. Its state machine has four states: `WD_OFF`, `WD_ARMED`, `WD_NEAR` and `WD_FIRED`. Reset puts it in `WD_ARMED`.
- `WD_ARMED` moves to `WD_NEAR` when the counter high byte equals the compare high byte.
- `WD_NEAR` moves to `WD_FIRED` when the counter low byte equals the compare low byte.
- A feed write moves `WD_ARMED`, `WD_NEAR` or `WD_FIRED` back to `WD_ARMED`.
- Clearing the enable moves any state to `WD_OFF`.
- Setting the enable moves `WD_OFF` to `WD_ARMED`.

While the watchdog is enabled, the run bit, the source select and the last channel's mode register are locked.

Top module: `shared_timer_unit`

## Requirements
- R1: After reset the counter is 0, run=1, source=0, overflow=0, watchdog enable=1, every channel flag and ch_out bit is 0, channel 5 compare low byte (0x26) reads 0xFF, and wd_reset_req is 0.
- R2: Register 0x00 holds run in bit 0, the source select in bits 3:1 and the overflow flag in bit 4. With run=1, source 4 adds one count per system clock, source 0 one count per 4 clocks and source 1 one count per 12 clocks.
- R3: Source 5 counts every 8th rising edge of osc_in and source 6 every 8th rising edge of rtc_in. Source 2 counts each rising edge of t0_ovf and source 3 each rising edge of cnt_in. Source 7 never advances the counter.
- R4: With run=0 the counter holds its value.
- R5: When the counter wraps from 0xFFFF to 0 the overflow flag is set. Writing 0 to bit 4 of 0x00 clears it, and writing 1 leaves it unchanged. A wrap in the same cycle as a clearing write leaves the flag set.
- R6: Writes to 0x03 and 0x04 load the counter low and high bytes, and reads of these addresses return them.
- R7: Channel n uses registers 0x10+4n (mode: bit 0 capture, bit 1 compare), +1 (flag, bit 0), +2 (value low) and +3 (value high). With capture on, a rising edge of ch_in[n] copies the counter into the value and sets the flag. Writing 0 to the flag clears it, but a capture in the same cycle wins.
- R8: With compare on, the flag sets when the counter advances onto the channel value, and ch_out[n] equals the flag.
- R9: While enabled (0x01 bit 0), the watchdog raises wd_reset_req when the counter low byte equals the channel 5 low byte, once the high byte has matched. With reset values it fires about 1024 clocks after reset.
- R10: A write to 0x27 while the watchdog is enabled loads the channel 5 high byte with counter high plus the offset in 0x02. This drops wd_reset_req and restarts the timeout.
- R11: While the watchdog is enabled, writes to the run and source fields and to 0x24 are ignored. Other channels' mode writes still take effect.
- R12: Writing 0 to 0x01 bit 0 drops wd_reset_req on the next cycle and lifts the locks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| osc_in | input | 1 | Slow oscillator clock, asynchronous |
| rtc_in | input | 1 | Real-time clock, asynchronous |
| t0_ovf | input | 1 | Timer-0 overflow pulse |
| cnt_in | input | 1 | External count input |
| ch_in | input | 6 | Per-channel capture inputs |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register address for read and write |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr |
| ch_out | output | 6 | Per-channel flag outputs |
| wd_reset_req | output | 1 | Watchdog reset request |

## Verification
Two pairs of functions can land on the same clock edge: a counter wrap against a software write that clears the overflow flag, and a synchronised capture edge against a write that clears that channel's flag. The bench loads the counter with 0xFFFF while it is stopped and uses back-to-back writes so that the run edge and the clear edge are consecutive. It also places a flag-clearing write on exactly the third edge after the capture input rises. In both cases a flag that stays set is the pass condition, and for the capture case a freshly loaded value must also appear. A later clear with no competing event must still take effect.

// File: rtl/stu_pkg.sv
package stu_pkg;
    typedef enum logic [2:0] {
        SRC_DIV4  = 3'd0,
        SRC_DIV12 = 3'd1,
        SRC_T0    = 3'd2,
        SRC_EXT   = 3'd3,
        SRC_SYS   = 3'd4,
        SRC_OSC8  = 3'd5,
        SRC_RTC8  = 3'd6,
        SRC_HOLD  = 3'd7
    } src_e;

    typedef enum logic [1:0] {
        WD_OFF   = 2'd0,
        WD_ARMED = 2'd1,
        WD_NEAR  = 2'd2,
        WD_FIRED = 2'd3
    } wd_state_e;

    localparam int A_CTRL  = 0;
    localparam int A_WDC   = 1;
    localparam int A_OFS   = 2;
    localparam int A_CLO   = 3;
    localparam int A_CHI   = 4;
    localparam int CH_BASE = 16;
    localparam int CTRL_OVF_BIT = 4;
endpackage

// File: rtl/stu_sync.sv
module stu_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic rise
);
    logic [STAGES:0] sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh <= '0;
        else        sh <= {sh[STAGES-1:0], d};
    end

    assign rise = sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/stu_timebase.sv
module stu_timebase
    import stu_pkg::*;
#(
    parameter int SYNC  = 2,
    parameter int DIV_A = 4,
    parameter int DIV_B = 12,
    parameter int DIV_C = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  src_e sel,
    input  logic osc_in,
    input  logic rtc_in,
    input  logic t0_ovf,
    input  logic cnt_in,
    output logic tick
);
    localparam int AW = $clog2(DIV_A);
    localparam int BW = $clog2(DIV_B);
    localparam int CW = $clog2(DIV_C);

    logic [AW-1:0] div_a;
    logic [BW-1:0] div_b;
    logic [CW-1:0] div_osc, div_rtc;
    logic [3:0]    raw, rise;
    logic          st_a, st_b, st_osc, st_rtc;

    assign raw = {cnt_in, t0_ovf, rtc_in, osc_in};

    for (genvar i = 0; i < 4; i++) begin : g_sync
        stu_sync #(.STAGES(SYNC)) u_sync (
            .clk (clk), .rst_n(rst_n), .d(raw[i]), .rise(rise[i])
        );
    end

    assign st_a   = (div_a == AW'(DIV_A - 1));
    assign st_b   = (div_b == BW'(DIV_B - 1));
    assign st_osc = rise[0] && (div_osc == CW'(DIV_C - 1));
    assign st_rtc = rise[1] && (div_rtc == CW'(DIV_C - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_a   <= '0;
            div_b   <= '0;
            div_osc <= '0;
            div_rtc <= '0;
        end else begin
            div_a <= st_a ? '0 : div_a + 1'b1;
            div_b <= st_b ? '0 : div_b + 1'b1;
            if (rise[0]) div_osc <= st_osc ? '0 : div_osc + 1'b1;
            if (rise[1]) div_rtc <= st_rtc ? '0 : div_rtc + 1'b1;
        end
    end

    always_comb begin
        unique case (sel)
            SRC_DIV4:  tick = st_a;
            SRC_DIV12: tick = st_b;
            SRC_T0:    tick = rise[2];
            SRC_EXT:   tick = rise[3];
            SRC_SYS:   tick = 1'b1;
            SRC_OSC8:  tick = st_osc;
            SRC_RTC8:  tick = st_rtc;
            default:   tick = 1'b0;
        endcase
    end
endmodule

// File: rtl/stu_wdog.sv
module stu_wdog
    import stu_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          feed,
    input  logic [CW-1:0] cnt,
    input  logic [CW-1:0] cmp,
    output logic          fire
);
    localparam int HW = CW / 2;

    wd_state_e st, nxt;
    logic hi_eq, lo_eq;

    assign hi_eq = (cnt[CW-1:HW] == cmp[CW-1:HW]);
    assign lo_eq = (cnt[HW-1:0]  == cmp[HW-1:0]);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= WD_ARMED;
        else        st <= nxt;
    end

    // next state
    always_comb begin
        nxt = st;
        unique case (st)
            WD_OFF:   if (en) nxt = WD_ARMED;
            WD_ARMED: if (!en) nxt = WD_OFF;
                      else if (feed) nxt = WD_ARMED;
                      else if (hi_eq) nxt = WD_NEAR;
            WD_NEAR:  if (!en) nxt = WD_OFF;
                      else if (feed) nxt = WD_ARMED;
                      else if (lo_eq) nxt = WD_FIRED;
            WD_FIRED: if (!en) nxt = WD_OFF;
                      else if (feed) nxt = WD_ARMED;
            default:  nxt = WD_OFF;
        endcase
    end

    // outputs
    always_comb begin
        fire = (st == WD_FIRED) && en;
    end
endmodule

// File: rtl/stu_channel.sv
module stu_channel #(
    parameter int            CW      = 16,
    parameter logic [CW-1:0] RST_VAL = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            block,
    input  logic            cap_rise,
    input  logic            inc,
    input  logic [CW-1:0]   cnt_q,
    input  logic [CW-1:0]   cnt_nxt,
    input  logic [CW/2-1:0] wdata,
    input  logic [CW/2-1:0] hi_data,
    input  logic            we_mode,
    input  logic            we_flag,
    input  logic            we_lo,
    input  logic            we_hi,
    output logic [1:0]      mode,
    output logic            flag,
    output logic [CW-1:0]   val
);
    localparam int HW = CW / 2;

    logic cap, hit;

    assign cap = !block && mode[0] && cap_rise;
    assign hit = !block && mode[1] && inc && (cnt_nxt == val);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode <= '0;
            flag <= 1'b0;
            val  <= RST_VAL;
        end else begin
            if (we_mode) mode <= wdata[1:0];
            if (cap || hit)              flag <= 1'b1;
            else if (we_flag && !wdata[0]) flag <= 1'b0;
            if (cap)        val <= cnt_q;
            else begin
                if (we_lo) val[HW-1:0]  <= wdata;
                if (we_hi) val[CW-1:HW] <= hi_data;
            end
        end
    end
endmodule

// File: rtl/shared_timer_unit.sv
module shared_timer_unit
    import stu_pkg::*;
#(
    parameter int CW         = 16,
    parameter int NCH        = 6,
    parameter int AW         = 6,
    parameter int SYNC       = 2,
    parameter int DIV_A      = 4,
    parameter int DIV_B      = 12,
    parameter int DIV_C      = 8,
    parameter int WD_LO_RST  = 255,
    parameter int WD_OFS_RST = 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            osc_in,
    input  logic            rtc_in,
    input  logic            t0_ovf,
    input  logic            cnt_in,
    input  logic [NCH-1:0]  ch_in,
    input  logic            reg_we,
    input  logic [AW-1:0]   reg_addr,
    input  logic [CW/2-1:0] reg_wdata,
    output logic [CW/2-1:0] reg_rdata,
    output logic [NCH-1:0]  ch_out,
    output logic            wd_reset_req
);
    localparam int HW   = CW / 2;
    localparam int WDCH = NCH - 1;

    logic          run_q, ovf_q, wden_q, tick, inc;
    src_e          src_q;
    logic [HW-1:0] ofs_q;
    logic [CW-1:0] cnt_q, cnt_nxt;
    logic          we_ctrl, we_wdc, we_ofs, we_clo, we_chi, cnt_we;

    logic [1:0]    ch_mode [NCH];
    logic [CW-1:0] ch_val  [NCH];
    logic [NCH-1:0] ch_flag, cap_rise;

    assign we_ctrl = reg_we && (reg_addr == AW'(A_CTRL));
    assign we_wdc  = reg_we && (reg_addr == AW'(A_WDC));
    assign we_ofs  = reg_we && (reg_addr == AW'(A_OFS));
    assign we_clo  = reg_we && (reg_addr == AW'(A_CLO));
    assign we_chi  = reg_we && (reg_addr == AW'(A_CHI));
    assign cnt_we  = we_clo || we_chi;
    assign cnt_nxt = cnt_q + 1'b1;
    assign inc     = run_q && tick && !cnt_we;

    stu_timebase #(.SYNC(SYNC), .DIV_A(DIV_A), .DIV_B(DIV_B), .DIV_C(DIV_C)) u_tb (
        .clk(clk), .rst_n(rst_n), .sel(src_q), .osc_in(osc_in), .rtc_in(rtc_in),
        .t0_ovf(t0_ovf), .cnt_in(cnt_in), .tick(tick)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q  <= 1'b1;
            src_q  <= SRC_DIV4;
            ovf_q  <= 1'b0;
            wden_q <= 1'b1;
            ofs_q  <= HW'(WD_OFS_RST);
            cnt_q  <= '0;
        end else begin
            if (we_ctrl && !wden_q) begin
                run_q <= reg_wdata[0];
                src_q <= src_e'(reg_wdata[3:1]);
            end
            if (inc && (cnt_q == '1))                    ovf_q <= 1'b1;
            else if (we_ctrl && !reg_wdata[CTRL_OVF_BIT]) ovf_q <= 1'b0;
            if (we_wdc) wden_q <= reg_wdata[0];
            if (we_ofs) ofs_q  <= reg_wdata;
            if (we_clo)      cnt_q[HW-1:0]  <= reg_wdata;
            else if (we_chi) cnt_q[CW-1:HW] <= reg_wdata;
            else if (inc)    cnt_q          <= cnt_nxt;
        end
    end

    for (genvar n = 0; n < NCH; n++) begin : g_ch
        localparam logic [CW-1:0] RV = (n == WDCH) ? CW'(WD_LO_RST) : '0;
        logic sel_n, is_wd, feed_n;
        logic [HW-1:0] hi_d;

        assign sel_n  = reg_we && (reg_addr[AW-1:2] == (AW-2)'(CH_BASE / 4 + n));
        assign is_wd  = (n == WDCH) && wden_q;
        assign feed_n = is_wd && sel_n && (reg_addr[1:0] == 2'd3);
        assign hi_d   = feed_n ? (cnt_q[CW-1:HW] + ofs_q) : reg_wdata;

        stu_sync #(.STAGES(SYNC)) u_cs (
            .clk(clk), .rst_n(rst_n), .d(ch_in[n]), .rise(cap_rise[n])
        );

        stu_channel #(.CW(CW), .RST_VAL(RV)) u_ch (
            .clk(clk), .rst_n(rst_n), .block(is_wd), .cap_rise(cap_rise[n]),
            .inc(inc), .cnt_q(cnt_q), .cnt_nxt(cnt_nxt), .wdata(reg_wdata),
            .hi_data(hi_d),
            .we_mode(sel_n && (reg_addr[1:0] == 2'd0) && !is_wd),
            .we_flag(sel_n && (reg_addr[1:0] == 2'd1)),
            .we_lo(sel_n && (reg_addr[1:0] == 2'd2)),
            .we_hi(sel_n && (reg_addr[1:0] == 2'd3)),
            .mode(ch_mode[n]), .flag(ch_flag[n]), .val(ch_val[n])
        );
    end

    logic wd_feed;
    assign wd_feed = g_ch[WDCH].feed_n;

    stu_wdog #(.CW(CW)) u_wd (
        .clk(clk), .rst_n(rst_n), .en(wden_q), .feed(wd_feed),
        .cnt(cnt_q), .cmp(ch_val[WDCH]), .fire(wd_reset_req)
    );

    assign ch_out = ch_flag;

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            AW'(A_CTRL): reg_rdata = HW'({ovf_q, src_q, run_q});
            AW'(A_WDC):  reg_rdata = HW'(wden_q);
            AW'(A_OFS):  reg_rdata = ofs_q;
            AW'(A_CLO):  reg_rdata = cnt_q[HW-1:0];
            AW'(A_CHI):  reg_rdata = cnt_q[CW-1:HW];
            default: begin
                for (int n = 0; n < NCH; n++) begin
                    if (reg_addr[AW-1:2] == (AW-2)'(CH_BASE / 4 + n)) begin
                        case (reg_addr[1:0])
                            2'd0:    reg_rdata = HW'(ch_mode[n]);
                            2'd1:    reg_rdata = HW'(ch_flag[n]);
                            2'd2:    reg_rdata = ch_val[n][HW-1:0];
                            default: reg_rdata = ch_val[n][CW-1:HW];
                        endcase
                    end
                end
            end
        endcase
    end
endmodule

// File: rtl/stu_checker.sv
module stu_checker
    import stu_pkg::*;
#(
    parameter int CW  = 16,
    parameter int AW  = 6,
    parameter int NCH = 6
) (
    input logic            clk,
    input logic            rst_n,
    input logic            reg_we,
    input logic [AW-1:0]   reg_addr,
    input logic [CW/2-1:0] reg_wdata,
    input logic [CW-1:0]   cnt_q,
    input logic            run_q,
    input logic [2:0]      src_q,
    input logic            ovf_q,
    input logic            wden_q,
    input logic [1:0]      ch5_mode,
    input logic            wd_reset_req
);
    logic cnt_we, ctrl_we, wdc_we, m5_we;

    assign cnt_we  = reg_we && (reg_addr == AW'(A_CLO) || reg_addr == AW'(A_CHI));
    assign ctrl_we = reg_we && (reg_addr == AW'(A_CTRL));
    assign wdc_we  = reg_we && (reg_addr == AW'(A_WDC));
    assign m5_we   = reg_we && (reg_addr == AW'(CH_BASE + 4 * (NCH - 1)));

    // R4
    a_r4_stopped_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_q && !cnt_we) |=> $stable(cnt_q));
    // R2
    a_r2_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_we |=> (cnt_q == $past(cnt_q) || cnt_q == CW'($past(cnt_q) + 1'b1)));
    // R5
    a_r5_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_q && !(ctrl_we && !reg_wdata[CTRL_OVF_BIT])) |=> ovf_q);
    a_r5_wrap_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == '1 && !cnt_we) |=> (cnt_q != '0 || ovf_q));
    // R11
    a_r11_ctrl_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (wden_q && ctrl_we) |=> ($stable(run_q) && $stable(src_q)));
    a_r11_mode_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (wden_q && m5_we) |=> $stable(ch5_mode));
    // R9
    a_r9_req_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
        wd_reset_req |-> wden_q);
    // R12
    a_r12_disable_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (wdc_we && !reg_wdata[0]) |=> !wd_reset_req);
endmodule

bind shared_timer_unit stu_checker #(.CW(CW), .AW(AW), .NCH(NCH)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .cnt_q(cnt_q), .run_q(run_q), .src_q(src_q),
    .ovf_q(ovf_q), .wden_q(wden_q), .ch5_mode(ch_mode[NCH-1]),
    .wd_reset_req(wd_reset_req)
);

// File: tb/sim_shared_timer_unit.sv
module sim_shared_timer_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       osc_in = 1'b0, rtc_in = 1'b0, t0_ovf = 1'b0, cnt_in = 1'b0;
    logic [5:0] ch_in = '0;
    logic       reg_we = 1'b0;
    logic [5:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic [5:0] ch_out;
    logic       wd_reset_req;
    int checks = 0, errors = 0;
    bit done = 0;

    shared_timer_unit u0 (
        .clk(clk), .rst_n(rst_n), .osc_in(osc_in), .rtc_in(rtc_in), .t0_ovf(t0_ovf),
        .cnt_in(cnt_in), .ch_in(ch_in), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ch_out(ch_out),
        .wd_reset_req(wd_reset_req)
    );

    always #5  clk = ~clk;
    always #20 osc_in = ~osc_in;
    always #30 rtc_in = ~rtc_in;

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        reg_we = 1'b1; reg_addr = 6'(a); reg_wdata = 8'(d);
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input int a, output int v);
        reg_addr = 6'(a);
        #1;
        v = int'(reg_rdata);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; ch_in = '0; t0_ovf = 0; cnt_in = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // R1, R9, R12
    task automatic t_reset_and_timeout();
        int v;
        do_reset();
        rd(0, v);    check("R1 ctrl", v, 8'h01);
        rd(1, v);    check("R1 wden", v, 1);
        rd(3, v);    check("R1 cnt lo", v, 0);
        rd(8'h26, v); check("R1 ch5 lo", v, 8'hFF);
        rd(8'h11, v); check("R1 ch0 flag", v, 0);
        check("R1 ch_out", int'(ch_out), 0);
        check("R1 req", int'(wd_reset_req), 0);
        idle(990);
        check("R9 no req yet", int'(wd_reset_req), 0);
        idle(110);
        check("R9 req raised", int'(wd_reset_req), 1);
        wr(1, 0);
        check("R12 req dropped", int'(wd_reset_req), 0);
        wr(0, 8'h18);
        rd(0, v);    check("R12 ctrl unlocked", v, 8'h08);
    endtask

    // R11
    task automatic t_locks();
        int v;
        do_reset();
        wr(0, 8'h1E);
        rd(0, v);     check("R11 ctrl locked", v, 8'h01);
        wr(8'h24, 3);
        rd(8'h24, v); check("R11 ch5 mode locked", v, 0);
        wr(8'h10, 1);
        rd(8'h10, v); check("R11 ch0 mode free", v, 1);
        wr(1, 0);
        wr(8'h24, 3);
        rd(8'h24, v); check("R12 ch5 mode free", v, 3);
        wr(8'h24, 0);
    endtask

    // R10
    task automatic t_feed();
        int v, h1, h2;
        bit ok = 1;
        do_reset();
        wr(2, 4);
        for (int i = 0; i < 8; i++) begin
            idle(400);
            wr(8'h27, 0);
            if (wd_reset_req !== 1'b0) ok = 0;
        end
        check("R10 fed no req", int'(ok), 1);
        idle(4000);
        check("R10 still waiting", int'(wd_reset_req), 0);
        idle(1300);
        check("R10 timeout req", int'(wd_reset_req), 1);
        rd(4, h1);
        wr(8'h27, 0);
        check("R10 feed drops req", int'(wd_reset_req), 0);
        rd(8'h27, v);
        rd(4, h2);
        if (h1 == h2) check("R10 reload value", v, (h1 + 4) & 8'hFF);
    endtask

    // R5, R6
    task automatic t_overflow();
        int v, lo, hi;
        do_reset();
        wr(1, 0);
        wr(0, 8'h18);
        wr(3, 8'h34); wr(4, 8'h12);
        rd(3, lo); rd(4, hi);
        check("R6 counter load", (hi << 8) | lo, 16'h1234);
        wr(3, 8'hFF); wr(4, 8'hFF);
        wr(0, 8'h19);
        wr(0, 8'h09);            // clear lands on the wrap edge
        rd(0, v); check("R5 set wins", (v >> 4) & 1, 1);
        wr(0, 8'h19);
        rd(0, v); check("R5 write 1 keeps", (v >> 4) & 1, 1);
        wr(0, 8'h09);
        rd(0, v); check("R5 write 0 clears", (v >> 4) & 1, 0);
        wr(0, 8'h08);
    endtask

    task automatic measure(input int src, input int n, output int cnt);
        int lo, hi;
        wr(0, 8'h10 | (src << 1));
        wr(3, 0); wr(4, 0);
        wr(0, 8'h11 | (src << 1));
        idle(n - 1);
        wr(0, 8'h10 | (src << 1));
        rd(3, lo); rd(4, hi);
        cnt = (hi << 8) | lo;
    endtask

    // R2, R3, R4
    task automatic t_rates();
        int c, lo;
        do_reset();
        wr(1, 0);
        measure(4, 50, c);   check("R2 sysclk", c, 50);
        measure(0, 400, c);  check("R2 div4", c, 100);
        measure(1, 1200, c); check("R2 div12", c, 100);
        measure(5, 3200, c); check("R3 osc div8", c, 100);
        measure(6, 4800, c); check("R3 rtc div8", c, 100);
        measure(7, 100, c);  check("R3 hold code", c, 0);
        wr(0, 8'h18);
        wr(3, 8'h55);
        idle(50);
        rd(3, lo); check("R4 stopped", lo, 8'h55);
        wr(3, 0);
        wr(0, 8'h15);        // src 2 run
        for (int i = 0; i < 5; i++) begin
            t0_ovf = 1; idle(2); t0_ovf = 0; idle(3);
        end
        idle(6);
        wr(0, 8'h14);
        rd(3, lo); check("R3 t0 pulses", lo, 5);
        wr(3, 0);
        wr(0, 8'h17);        // src 3 run
        for (int i = 0; i < 7; i++) begin
            cnt_in = 1; idle(2); cnt_in = 0; idle(3);
        end
        idle(6);
        wr(0, 8'h16);
        rd(3, lo); check("R3 count input", lo, 7);
    endtask

    // R7
    task automatic t_capture();
        int v, lo, hi;
        do_reset();
        wr(1, 0);
        wr(0, 8'h18);
        wr(3, 8'hBC); wr(4, 8'h0A);
        wr(8'h10, 1);
        ch_in[0] = 1; ch_in[3] = 1;
        idle(5);
        rd(8'h12, lo); rd(8'h13, hi);
        check("R7 captured", (hi << 8) | lo, 16'h0ABC);
        rd(8'h11, v); check("R7 flag set", v, 1);
        check("R7 ch_out", int'(ch_out[0]), 1);
        rd(8'h1D, v); check("R7 mode off no capture", v, 0);
        ch_in[0] = 0;
        idle(5);
        wr(3, 8'hEF); wr(4, 8'h0D);
        ch_in[0] = 1;
        idle(2);
        wr(8'h11, 0);        // clear on the capture edge
        rd(8'h11, v); check("R7 capture beats clear", v, 1);
        rd(8'h12, lo); rd(8'h13, hi);
        check("R7 recapture", (hi << 8) | lo, 16'h0DEF);
        wr(8'h11, 0);
        rd(8'h11, v); check("R7 flag cleared", v, 0);
        ch_in = '0;
    endtask

    // R8
    task automatic t_compare();
        int v;
        do_reset();
        wr(1, 0);
        wr(0, 8'h18);
        wr(8'h14, 2);
        wr(8'h16, 8'h05); wr(8'h17, 8'h01);
        wr(3, 8'h00); wr(4, 8'h01);
        wr(0, 8'h19);
        idle(2);
        rd(8'h15, v); check("R8 not yet", v, 0);
        check("R8 ch_out low", int'(ch_out[1]), 0);
        idle(8);
        rd(8'h15, v); check("R8 match flag", v, 1);
        check("R8 ch_out high", int'(ch_out[1]), 1);
        wr(0, 8'h18);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset_and_timeout();
        t_locks();
        t_feed();
        t_overflow();
        t_rates();
        t_capture();
        t_compare();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule